// File: doc/BRIEF.md
# Fixed-Point Audio Sample Decimator

This block sits between a set of tone generators that update once per CPU cycle and an audio path that runs at a much lower, programmable sample rate. Each accepted input beat carries one cycle's worth of channel levels: two square-wave levels, a triangle level, a noise level and a delta-modulation level. The block adds a 32-bit phase increment to a fractional phase register on every beat. When the sum reaches 2^32, that beat closes the current output period. The wrapped phase keeps the fractional remainder, so the spacing between outputs varies by one beat where it must, and the long-run output rate is exact.

Between outputs the block keeps four running sums: the two square waves together, triangle, noise and delta-modulation. It also counts the beats it has summed. When a period closes, four sequential dividers work in parallel and turn each sum into a box-filter mean with four fractional bits. The means are presented on an output stream. The increment is computed outside the block as floor(2^32 x sample_rate / 1789773). For 44.1 kHz this gives 105827978. A five-bit mute mask removes single channels before they are summed.

Both data interfaces use valid/ready. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output transfers where `out_valid` and `out_ready` are both high. `in_ready` is low from the beat that closes a period until its result has been taken, so no beat is lost or counted twice while the divide runs or while the consumer holds back. Once `out_valid` rises, the output data does not change until it is taken.

Top module: `audio_decimator`

## Requirements
- R1: After reset `out_valid` is 0, and `in_ready` is 1 while `phase_inc` is held constant. The phase, the sums and the beat count are all zero, so the first output covers only beats accepted after reset.
- R2: Each accepted beat adds `phase_inc` to a 32-bit phase. If the 33-bit sum is at least 2^32, that beat closes the period, the phase becomes the sum minus 2^32, and `in_ready` is low in the following cycle. Otherwise the phase becomes the sum and `in_ready` stays high.
- R3: The square-wave output averages the per-beat value `in_sq_a + in_sq_b`. The triangle, noise and delta-modulation outputs each average their own input alone.
- R4: Every output equals floor(16 x sum / count), where the sum and count cover the beats of the period including the closing beat, and the count is forced to at least 1. The low 4 bits of each output are the fraction. The sums and the count are cleared when the period closes.
- R5: The mute mask zeroes a channel before it is summed. Bit 0 zeroes `in_sq_a`, bit 1 `in_sq_b`, bit 2 triangle, bit 3 noise and bit 4 delta-modulation.
- R6: The beat count saturates at 2^CNT_W-1. Once it is saturated, further beats in that period change neither the count nor the sums, but they still advance the phase.
- R7: In any cycle where `phase_inc` differs from its value in the previous cycle, `in_ready` is low and the phase, the sums and the count are cleared.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all four outputs stay stable. `in_ready` stays low for as long as a result is pending.
- R9: In the cycle after an output transfer, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_inc | input | PHASE_W | Phase added per beat; any change restarts accumulation |
| mute_mask | input | 5 | Per-channel zeroing mask |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_sq_a | input | SQ_W | First square-wave level |
| in_sq_b | input | SQ_W | Second square-wave level |
| in_tri | input | TRI_W | Triangle level |
| in_noise | input | NOI_W | Noise level |
| in_dmc | input | DMC_W | Delta-modulation level |
| out_valid | output | 1 | Averaged sample valid |
| out_ready | input | 1 | Consumer takes the sample |
| out_sq | output | SQ_W+1+FRAC_W | Mean of the square-wave sum |
| out_tri | output | TRI_W+FRAC_W | Mean triangle level |
| out_noise | output | NOI_W+FRAC_W | Mean noise level |
| out_dmc | output | DMC_W+FRAC_W | Mean delta-modulation level |

## Verification
A phase register that is off by even one unit shows up as an output that arrives one beat early or late. The bench sees this at the first period boundary it affects, because it checks `in_ready` after every single beat. A sum or count that was not cleared, or was cleared at the wrong time, shows up in the value of the very next output as a wrong mean. A saturation slip shows up only in a period longer than the count limit, so a narrow-count second instance exposes it within about twenty beats. A divider or handshake fault shows up within one output, either as a wrong quotient or as data that moves while the output is stalled.

// File: rtl/audec_pkg.sv
package audec_pkg;
  localparam int NGRP      = 4;
  localparam int GRP_SQ    = 0;
  localparam int GRP_TRI   = 1;
  localparam int GRP_NOISE = 2;
  localparam int GRP_DMC   = 3;

  // mute mask bit positions
  localparam int MB_SQA   = 0;
  localparam int MB_SQB   = 1;
  localparam int MB_TRI   = 2;
  localparam int MB_NOISE = 3;
  localparam int MB_DMC   = 4;

  typedef enum logic [1:0] {ST_GATHER, ST_DIVIDE, ST_OFFER} dec_state_e;

  // level width of a channel group
  function automatic int grp_width(int g, int sq_w, int tri_w, int noi_w, int dmc_w);
    case (g)
      GRP_SQ:    return sq_w + 1;
      GRP_TRI:   return tri_w;
      GRP_NOISE: return noi_w;
      default:   return dmc_w;
    endcase
  endfunction
endpackage

// File: rtl/audec_level_gate.sv
module audec_level_gate #(
  parameter int SQ_W  = 4,
  parameter int TRI_W = 4,
  parameter int NOI_W = 4,
  parameter int DMC_W = 7
) (
  input  logic [4:0]       mute_mask,
  input  logic [SQ_W-1:0]  sq_a,
  input  logic [SQ_W-1:0]  sq_b,
  input  logic [TRI_W-1:0] tri_lvl,
  input  logic [NOI_W-1:0] noise_lvl,
  input  logic [DMC_W-1:0] dmc_lvl,
  output logic [SQ_W:0]    sq_sum,
  output logic [TRI_W-1:0] tri_g,
  output logic [NOI_W-1:0] noise_g,
  output logic [DMC_W-1:0] dmc_g
);
  import audec_pkg::*;

  logic [SQ_W-1:0] sq_a_g, sq_b_g;

  always_comb begin
    sq_a_g  = mute_mask[MB_SQA]   ? '0 : sq_a;
    sq_b_g  = mute_mask[MB_SQB]   ? '0 : sq_b;
    tri_g   = mute_mask[MB_TRI]   ? '0 : tri_lvl;
    noise_g = mute_mask[MB_NOISE] ? '0 : noise_lvl;
    dmc_g   = mute_mask[MB_DMC]   ? '0 : dmc_lvl;
    sq_sum  = {1'b0, sq_a_g} + {1'b0, sq_b_g};
  end
endmodule

// File: rtl/audec_phase_acc.sv
module audec_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [PHASE_W-1:0] inc,
  output logic               wrap
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W:0]   sum;

  assign sum  = {1'b0, phase_q} + {1'b0, inc};
  assign wrap = sum[PHASE_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase_q <= '0;
    else if (step)       phase_q <= sum[PHASE_W-1:0];
  end
endmodule

// File: rtl/audec_box_accum.sv
module audec_box_accum #(
  parameter int LVL_W = 4,
  parameter int CNT_W = 16,
  localparam int ACC_W = LVL_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add,
  input  logic             hold,
  input  logic [LVL_W-1:0] lvl,
  output logic [ACC_W-1:0] acc_nxt
);
  logic [ACC_W-1:0] acc_q;

  assign acc_nxt = hold ? acc_q : acc_q + ACC_W'(lvl);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc_q <= '0;
    else if (add)        acc_q <= acc_nxt;
  end
endmodule

// File: rtl/audec_seq_div.sv
module audec_seq_div #(
  parameter int N   = 24,
  parameter int D   = 16,
  parameter int Q_W = 8,
  localparam int STEP_W = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   num,
  input  logic [D-1:0]   den,
  output logic           busy,
  output logic [Q_W-1:0] quo
);
  logic [N-1:0]      num_q;
  logic [D-1:0]      den_q, rem_q;
  logic [Q_W-1:0]    quo_q;
  logic [STEP_W-1:0] step_q;
  logic [D:0]        trial;
  logic              ge;

  assign trial = {rem_q, num_q[N-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign busy  = step_q != '0;
  assign quo   = quo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
    end else if (start) begin
      num_q  <= num;
      den_q  <= den;
      rem_q  <= '0;
      quo_q  <= '0;
      step_q <= STEP_W'(N);
    end else if (busy) begin
      rem_q  <= ge ? (trial[D-1:0] - den_q) : trial[D-1:0];
      quo_q  <= {quo_q[Q_W-2:0], ge};
      num_q  <= {num_q[N-2:0], 1'b0};
      step_q <= step_q - 1'b1;
    end
  end
endmodule

// File: rtl/audio_decimator.sv
module audio_decimator #(
  parameter int SQ_W    = 4,
  parameter int TRI_W   = 4,
  parameter int NOI_W   = 4,
  parameter int DMC_W   = 7,
  parameter int CNT_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int PHASE_W = 32,
  localparam int OSQ_W  = SQ_W + 1 + FRAC_W,
  localparam int OTRI_W = TRI_W + FRAC_W,
  localparam int ONOI_W = NOI_W + FRAC_W,
  localparam int ODMC_W = DMC_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [4:0]         mute_mask,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SQ_W-1:0]    in_sq_a,
  input  logic [SQ_W-1:0]    in_sq_b,
  input  logic [TRI_W-1:0]   in_tri,
  input  logic [NOI_W-1:0]   in_noise,
  input  logic [DMC_W-1:0]   in_dmc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OSQ_W-1:0]   out_sq,
  output logic [OTRI_W-1:0]  out_tri,
  output logic [ONOI_W-1:0]  out_noise,
  output logic [ODMC_W-1:0]  out_dmc
);
  import audec_pkg::*;

  dec_state_e         st_q;
  logic [PHASE_W-1:0] inc_q;
  logic               rate_chg, accept, wrap, emit, cnt_sat;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt, den;
  logic [NGRP-1:0]    busy_v;

  logic [SQ_W:0]      g_sq;
  logic [TRI_W-1:0]   g_tri;
  logic [NOI_W-1:0]   g_noise;
  logic [DMC_W-1:0]   g_dmc;

  assign rate_chg = phase_inc != inc_q;
  assign in_ready = (st_q == ST_GATHER) && !rate_chg;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && wrap;
  assign out_valid = st_q == ST_OFFER;

  assign cnt_sat = &cnt_q;
  assign cnt_nxt = cnt_sat ? cnt_q : cnt_q + 1'b1;
  assign den     = (cnt_nxt == '0) ? CNT_W'(1) : cnt_nxt;

  // tracks the increment seen in the previous cycle
  always_ff @(posedge clk) inc_q <= phase_inc;

  always_ff @(posedge clk) begin
    if (!rst_n || rate_chg)       cnt_q <= '0;
    else if (emit)                cnt_q <= '0;
    else if (accept)              cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_GATHER;
    else begin
      case (st_q)
        ST_GATHER: if (emit)       st_q <= ST_DIVIDE;
        ST_DIVIDE: if (~|busy_v)   st_q <= ST_OFFER;
        ST_OFFER:  if (out_ready)  st_q <= ST_GATHER;
        default:                   st_q <= ST_GATHER;
      endcase
    end
  end

  audec_level_gate #(
    .SQ_W(SQ_W), .TRI_W(TRI_W), .NOI_W(NOI_W), .DMC_W(DMC_W)
  ) u_gate (
    .mute_mask(mute_mask), .sq_a(in_sq_a), .sq_b(in_sq_b), .tri_lvl(in_tri),
    .noise_lvl(in_noise), .dmc_lvl(in_dmc),
    .sq_sum(g_sq), .tri_g(g_tri), .noise_g(g_noise), .dmc_g(g_dmc)
  );

  audec_phase_acc #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(rate_chg), .step(accept),
    .inc(phase_inc), .wrap(wrap)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LW  = grp_width(g, SQ_W, TRI_W, NOI_W, DMC_W);
    localparam int AW  = LW + CNT_W;
    localparam int NW  = AW + FRAC_W;
    localparam int QW  = LW + FRAC_W;
    logic [LW-1:0] lvl;
    logic [AW-1:0] acc_nxt;
    logic [QW-1:0] quo;

    if (g == GRP_SQ) begin : g_sq_sel
      assign lvl    = g_sq;
      assign out_sq = quo;
    end else if (g == GRP_TRI) begin : g_tri_sel
      assign lvl     = g_tri;
      assign out_tri = quo;
    end else if (g == GRP_NOISE) begin : g_noise_sel
      assign lvl       = g_noise;
      assign out_noise = quo;
    end else begin : g_dmc_sel
      assign lvl     = g_dmc;
      assign out_dmc = quo;
    end

    audec_box_accum #(.LVL_W(LW), .CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(rate_chg || emit), .add(accept),
      .hold(cnt_sat), .lvl(lvl), .acc_nxt(acc_nxt)
    );

    audec_seq_div #(.N(NW), .D(CNT_W), .Q_W(QW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(emit),
      .num({acc_nxt, {FRAC_W{1'b0}}}), .den(den),
      .busy(busy_v[g]), .quo(quo)
    );
  end
endmodule

// File: rtl/audec_checker.sv
module audec_checker #(
  parameter int SQ_W    = 4,
  parameter int TRI_W   = 4,
  parameter int NOI_W   = 4,
  parameter int DMC_W   = 7,
  parameter int FRAC_W  = 4,
  parameter int PHASE_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [PHASE_W-1:0]          phase_inc,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [SQ_W+FRAC_W:0]        out_sq,
  input logic [TRI_W+FRAC_W-1:0]     out_tri,
  input logic [NOI_W+FRAC_W-1:0]     out_noise,
  input logic [DMC_W+FRAC_W-1:0]     out_dmc
);
  localparam logic [SQ_W+FRAC_W:0] SQ_MAX = (SQ_W+FRAC_W+1)'(2 * ((1 << SQ_W) - 1)) << FRAC_W;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r8_no_intake_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sq) && $stable(out_tri)
                                  && $stable(out_noise) && $stable(out_dmc));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  a_r7_rate_change_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(rst_n) && phase_inc != $past(phase_inc)) |-> !in_ready);

  a_r4_sq_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sq <= SQ_MAX);
endmodule

bind audio_decimator audec_checker #(
  .SQ_W(SQ_W), .TRI_W(TRI_W), .NOI_W(NOI_W), .DMC_W(DMC_W),
  .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sq(out_sq),
  .out_tri(out_tri), .out_noise(out_noise), .out_dmc(out_dmc)
);

// File: tb/audio_decimator_tb_top.sv
module audio_decimator_tb_top;
  localparam longint TWO32 = 64'd1 << 32;
  localparam logic [31:0] INC_44K = 32'(((64'd1 << 32) * 64'd44100) / 64'd1789773);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // main instance
  logic [31:0] phase_inc = INC_44K;
  logic [4:0]  mute_mask = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [3:0]  in_sq_a = '0, in_sq_b = '0, in_tri = '0, in_noise = '0;
  logic [6:0]  in_dmc = '0;
  logic [8:0]  out_sq;
  logic [7:0]  out_tri, out_noise;
  logic [10:0] out_dmc;

  audio_decimator dut_i (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .mute_mask(mute_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_sq_a(in_sq_a), .in_sq_b(in_sq_b),
    .in_tri(in_tri), .in_noise(in_noise), .in_dmc(in_dmc),
    .out_valid(out_valid), .out_ready(out_ready), .out_sq(out_sq),
    .out_tri(out_tri), .out_noise(out_noise), .out_dmc(out_dmc)
  );

  // narrow-count instance for saturation
  logic [31:0] s_inc = 32'd214748365;
  logic        s_valid = 1'b0, s_ready, s_ovalid, s_oready = 1'b0;
  logic [3:0]  s_sqa = '0, s_tri = '0;
  logic [8:0]  s_osq;
  logic [7:0]  s_otri, s_onoise;
  logic [10:0] s_odmc;

  audio_decimator #(.CNT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .phase_inc(s_inc), .mute_mask(5'b0),
    .in_valid(s_valid), .in_ready(s_ready), .in_sq_a(s_sqa), .in_sq_b(4'd0),
    .in_tri(s_tri), .in_noise(4'd0), .in_dmc(7'd0),
    .out_valid(s_ovalid), .out_ready(s_oready), .out_sq(s_osq),
    .out_tri(s_otri), .out_noise(s_onoise), .out_dmc(s_odmc)
  );

  // reference model state
  longint m_phase;
  longint m_acc [4];
  longint m_cnt;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mean16(input longint acc, input longint cnt);
    return (acc * 16) / ((cnt == 0) ? 1 : cnt);
  endfunction

  task automatic model_clear();
    m_phase = 0;
    m_cnt = 0;
    for (int g = 0; g < 4; g++) m_acc[g] = 0;
  endtask

  // called at a negedge; takes the pending sample with a random stall
  task automatic collect();
    longint e_sq, e_tri, e_no, e_dmc;
    int hold;
    e_sq = mean16(m_acc[0], m_cnt); e_tri = mean16(m_acc[1], m_cnt);
    e_no = mean16(m_acc[2], m_cnt); e_dmc = mean16(m_acc[3], m_cnt);
    while (!out_valid) begin
      if (in_ready) begin
        chk(1'b0, "R8 in_ready while result pending", 1, 0);
        break;
      end
      @(negedge clk);
    end
    hold = $urandom % 4;
    for (int h = 0; h <= hold; h++) begin
      chk(out_valid == 1'b1, "R8 out_valid held", out_valid, 1);
      chk(in_ready == 1'b0, "R8 in_ready low while offered", in_ready, 0);
      chk(out_sq == 9'(e_sq), "R3 R4 square mean", out_sq, e_sq);
      chk(out_tri == 8'(e_tri), "R3 R4 triangle mean", out_tri, e_tri);
      chk(out_noise == 8'(e_no), "R3 R4 noise mean", out_noise, e_no);
      chk(out_dmc == 11'(e_dmc), "R3 R4 dmc mean", out_dmc, e_dmc);
      if (h == hold) out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R9 out_valid after transfer", out_valid, 0);
    chk(in_ready == 1'b1, "R9 in_ready after transfer", in_ready, 1);
    for (int g = 0; g < 4; g++) m_acc[g] = 0;
    m_cnt = 0;
  endtask

  // one beat; entered and left at a negedge
  task automatic beat(input logic [3:0] a, input logic [3:0] b, input logic [3:0] t,
                      input logic [3:0] n, input logic [6:0] d);
    longint s;
    while (!in_ready) @(negedge clk);
    in_sq_a = a; in_sq_b = b; in_tri = t; in_noise = n; in_dmc = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    m_acc[0] += (mute_mask[0] ? 0 : a) + (mute_mask[1] ? 0 : b);
    m_acc[1] += mute_mask[2] ? 0 : t;
    m_acc[2] += mute_mask[3] ? 0 : n;
    m_acc[3] += mute_mask[4] ? 0 : d;
    m_cnt++;
    s = m_phase + longint'(phase_inc);
    if (s >= TWO32) begin
      m_phase = s - TWO32;
      chk(in_ready == 1'b0, "R2 period closes on wrap", in_ready, 0);
      collect();
    end else begin
      m_phase = s;
      chk(in_ready == 1'b1, "R2 no close below 2^32", in_ready, 1);
    end
  endtask

  task automatic rand_beat();
    beat(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 7'($urandom));
  endtask

  task automatic set_rate(input logic [31:0] v);
    phase_inc = v;
    #1;
    chk(in_ready == 1'b0, "R7 in_ready low on rate change", in_ready, 0);
    @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2 R3 R4 default rate with random levels
    for (int i = 0; i < 250; i++) rand_beat();

    // R5 full mute gives zero means
    mute_mask = 5'b11111;
    for (int i = 0; i < 60; i++) rand_beat();
    mute_mask = '0;

    // R7 change mid-period discards the partial sums
    for (int i = 0; i < 7; i++) beat(4'd15, 4'd15, 4'd15, 4'd15, 7'd127);
    set_rate(32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) beat(4'd1, 4'd2, 4'd3, 4'd4, 7'd5);

    // R1 reset mid-period discards the partial sums
    set_rate(32'h4000_0000);
    beat(4'd9, 4'd9, 4'd9, 4'd9, 7'd99);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_clear();
    chk(out_valid == 1'b0, "R1 out_valid after second reset", out_valid, 0);
    for (int i = 0; i < 8; i++) beat(4'd3, 4'd0, 4'd7, 4'd1, 7'd20);

    // random rates and masks (R2 R3 R4 R5 R7 R8)
    for (int r = 0; r < 12; r++) begin
      set_rate(32'(32'hFFFF_FFFF / (2 + ($urandom % 30))) + 32'd1);
      mute_mask = (($urandom % 3) == 0) ? 5'($urandom) : 5'd0;
      for (int i = 0; i < 80; i++) rand_beat();
    end
    mute_mask = '0;

    // R6 count saturation on the narrow instance: 20 beats, limit 15
    for (int i = 0; i < 20; i++) begin
      while (!s_ready) @(negedge clk);
      s_sqa = (i < 15) ? 4'd1 : 4'd15;
      s_tri = (i < 15) ? 4'd2 : 4'd15;
      s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      if (i == 18) chk(s_ready == 1'b1, "R6 no close before beat 20", s_ready, 1);
    end
    while (!s_ovalid) @(negedge clk);
    chk(s_osq == 9'd16, "R6 square mean frozen at saturation", s_osq, 16);
    chk(s_otri == 8'd32, "R6 triangle mean frozen at saturation", s_otri, 32);
    s_oready = 1'b1;
    @(negedge clk);
    s_oready = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule